// File: doc/BRIEF.md
# Receive Interrupt Mode Controller

This block decides when one serial receive channel asks the processor for service. Each time a received character lands at the head of the receive FIFO, the block gets a one-cycle event together with that character's parity and overrun flags. It keeps a character-available bit that software polls, and two error bits that stay set until software clears them. From the selected interrupt mode it raises an interrupt request and a two-bit vector modifier. The modifier tells an ordinary receive interrupt apart from a special receive condition.

Software picks one of four modes: polling with no interrupts, interrupt on the first character only, or interrupt on every character (two codes). Two commands change state. An error reset clears the held error bits. A re-arm command makes the next character raise the first-character interrupt again. A special receive condition can raise an interrupt in either interrupt mode. It applies when an overrun is present. It also applies when a parity error is present, but only in every-character mode and only when parity special conditions are enabled. A vector-modifier enable chooses whether the condition shows in the code.

Top module: `rx_irq_ctrl`

## Requirements
- R1: After reset, avail, par_err, ovr_err and irq are 0 and vec is 2'b00.
- R2: avail goes to 1 in the cycle after char_top and goes to 0 in the cycle after rd_strobe. When both strobes occur in the same cycle, avail stays 1.
- R3: par_err and ovr_err are set from char_par and char_ovr when char_top is high. They stay set through reads and later characters, and clear only on err_reset. A new error arriving in the same cycle as err_reset is kept.
- R4: In mode 2'b00 (polling), irq never asserts, even with an error present. Entering mode 2'b00 drops any pending request by the next cycle.
- R5: Modes 2'b10 and 2'b11 (every character) raise irq in the cycle after every char_top. When there is no special condition, vec is 2'b01.
- R6: Mode 2'b01 (first character only) raises irq for the first char_top after the mode is entered. Later clean characters raise no irq.
- R7: A rearm strobe makes the next char_top in mode 2'b01 raise irq again with vec 2'b01.
- R8: A character is a special condition in any interrupt mode when overrun is set, either held or current. It is also a special condition when parity is set, held or current, but only in every-character mode with par_sc_en high. A special condition raises irq even in first-character mode after the first character. Its vec is 2'b10 when sav_en is 1 and 2'b01 when sav_en is 0. Parity alone never raises irq in mode 2'b01.
- R9: irq stays high until rd_strobe. If the pending request was a special condition, err_reset also drops it. vec is 2'b00 whenever irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_top | input | 1 | One-cycle event: a character reached the FIFO head |
| char_par | input | 1 | Parity error flag of that character |
| char_ovr | input | 1 | Overrun flag of that character |
| rd_strobe | input | 1 | Receive buffer read |
| int_mode | input | 2 | 00 poll, 01 first char, 10/11 every char |
| sav_en | input | 1 | Special condition modifies the vector code |
| par_sc_en | input | 1 | Parity counts as special condition in every-char mode |
| err_reset | input | 1 | Clear held error bits |
| rearm | input | 1 | Re-arm the first-character interrupt |
| avail | output | 1 | Character-available status |
| par_err | output | 1 | Held parity error |
| ovr_err | output | 1 | Held overrun error |
| irq | output | 1 | Interrupt request |
| vec | output | 2 | 00 none, 01 receive char, 10 special condition |

## Verification
The bench builds the block with its default parameters: two held error flags and a two-bit mode and vector code. With these defaults, every mode code can be reached, including the duplicate every-character code. The bench moves through the modes in order so that arming happens both by entering first-character mode and by the rearm command. It also covers error bits held across reads, with the vector enable both on and off. It includes a cycle where a read and a new character coincide.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
    localparam int MODE_W = 2;
    localparam int VEC_W  = 2;
    localparam int N_ERR  = 2;
    localparam int ERR_PAR = 0;
    localparam int ERR_OVR = 1;

    typedef enum logic [MODE_W-1:0] {
        MODE_POLL  = 2'b00,
        MODE_FIRST = 2'b01,
        MODE_EVERY = 2'b10,
        MODE_EVALT = 2'b11
    } rxi_mode_e;

    typedef enum logic [VEC_W-1:0] {
        VEC_NONE    = 2'b00,
        VEC_CHAR    = 2'b01,
        VEC_SPECIAL = 2'b10
    } rxi_vec_e;
endpackage

// File: rtl/rxi_err_latch.sv
module rxi_err_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         char_top,
    input  logic [N-1:0] flag_in,
    input  logic         clr,
    output logic [N-1:0] sticky
);
    typedef struct packed {
        logic [N-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (clr) st_d.bits[i] = 1'b0;
            if (char_top && flag_in[i]) st_d.bits[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sticky = st_q.bits;
endmodule

// File: rtl/rxi_arm.sv
module rxi_arm
    import rxi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              char_top,
    input  logic              rearm,
    output logic              armed
);
    typedef struct packed {
        logic armed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rxi_mode_e'(mode) != MODE_FIRST) st_d.armed = 1'b1;
        else if (char_top)                   st_d.armed = 1'b0;
        if (rearm) st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b1};
        else        st_q <= st_d;
    end

    assign armed = st_q.armed;
endmodule

// File: rtl/rxi_req.sv
module rxi_req
    import rxi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              char_top,
    input  logic              rd_strobe,
    input  logic              err_reset,
    input  logic              armed,
    input  logic              special,
    input  logic              sav_en,
    output logic              irq,
    output logic [VEC_W-1:0]  vec
);
    typedef struct packed {
        logic     pend;
        logic     spec;
        rxi_vec_e code;
    } st_t;

    st_t       st_d, st_q;
    rxi_mode_e m;
    logic      every, first, normal_hit;

    always_comb begin
        m          = rxi_mode_e'(mode);
        every      = (m == MODE_EVERY) || (m == MODE_EVALT);
        first      = (m == MODE_FIRST);
        normal_hit = every || (first && armed);

        st_d = st_q;
        if (rd_strobe)                st_d.pend = 1'b0;
        if (err_reset && st_q.spec)   st_d.pend = 1'b0;
        if (char_top && m != MODE_POLL) begin
            if (special) begin
                st_d.pend = 1'b1;
                st_d.spec = 1'b1;
                st_d.code = sav_en ? VEC_SPECIAL : VEC_CHAR;
            end else if (normal_hit) begin
                st_d.pend = 1'b1;
                st_d.spec = 1'b0;
                st_d.code = VEC_CHAR;
            end
        end
        if (m == MODE_POLL) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pend: 1'b0, spec: 1'b0, code: VEC_NONE};
        else        st_q <= st_d;
    end

    assign irq = st_q.pend;
    assign vec = st_q.pend ? st_q.code : VEC_NONE;
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
    import rxi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_top,
    input  logic              char_par,
    input  logic              char_ovr,
    input  logic              rd_strobe,
    input  logic [MODE_W-1:0] int_mode,
    input  logic              sav_en,
    input  logic              par_sc_en,
    input  logic              err_reset,
    input  logic              rearm,
    output logic              avail,
    output logic              par_err,
    output logic              ovr_err,
    output logic              irq,
    output logic [VEC_W-1:0]  vec
);
    typedef struct packed {
        logic avail;
    } st_t;

    st_t             st_d, st_q;
    logic [N_ERR-1:0] flags_now, sticky;
    logic             armed, special, par_counts;
    rxi_mode_e        m;

    assign flags_now[ERR_PAR] = char_par;
    assign flags_now[ERR_OVR] = char_ovr;

    rxi_err_latch #(.N(N_ERR)) u_err (
        .clk(clk), .rst_n(rst_n), .char_top(char_top),
        .flag_in(flags_now), .clr(err_reset), .sticky(sticky)
    );

    rxi_arm u_arm (
        .clk(clk), .rst_n(rst_n), .mode(int_mode),
        .char_top(char_top), .rearm(rearm), .armed(armed)
    );

    always_comb begin
        m          = rxi_mode_e'(int_mode);
        par_counts = par_sc_en && (m == MODE_EVERY || m == MODE_EVALT);
        special    = (sticky[ERR_OVR] || char_ovr)
                   || (par_counts && (sticky[ERR_PAR] || char_par));
        st_d = st_q;
        if (rd_strobe) st_d.avail = 1'b0;
        if (char_top)  st_d.avail = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rxi_req u_req (
        .clk(clk), .rst_n(rst_n), .mode(int_mode), .char_top(char_top),
        .rd_strobe(rd_strobe), .err_reset(err_reset), .armed(armed),
        .special(special), .sav_en(sav_en), .irq(irq), .vec(vec)
    );

    assign avail   = st_q.avail;
    assign par_err = sticky[ERR_PAR];
    assign ovr_err = sticky[ERR_OVR];
endmodule

// File: rtl/rx_irq_ctrl_chk.sv
module rx_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       char_top,
    input logic       rd_strobe,
    input logic [1:0] int_mode,
    input logic       err_reset,
    input logic       avail,
    input logic       par_err,
    input logic       ovr_err,
    input logic       irq,
    input logic [1:0] vec
);
    // R2
    avail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_top |=> avail);
    // R3
    par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !err_reset) |=> par_err);
    // R3
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && !err_reset) |=> ovr_err);
    // R4
    poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode == 2'b00) |=> !irq);
    // R5
    every_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_top && int_mode[1]) |=> irq);
    // R9
    read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !char_top) |=> !irq);
    // R9
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (vec == 2'b00));
endmodule

bind rx_irq_ctrl rx_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .char_top(char_top), .rd_strobe(rd_strobe),
    .int_mode(int_mode), .err_reset(err_reset), .avail(avail),
    .par_err(par_err), .ovr_err(ovr_err), .irq(irq), .vec(vec)
);

// File: tb/tb_rx_irq_ctrl.sv
module tb_rx_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_top = 0, char_par = 0, char_ovr = 0, rd_strobe = 0;
    logic [1:0] int_mode = 2'b00;
    logic       sav_en = 1, par_sc_en = 0, err_reset = 0, rearm = 0;
    logic       avail, par_err, ovr_err, irq;
    logic [1:0] vec;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    typedef struct {
        logic       avail, par, ovr, irq;
        logic [1:0] vec;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .char_top(char_top), .char_par(char_par),
        .char_ovr(char_ovr), .rd_strobe(rd_strobe), .int_mode(int_mode),
        .sav_en(sav_en), .par_sc_en(par_sc_en), .err_reset(err_reset),
        .rearm(rearm), .avail(avail), .par_err(par_err), .ovr_err(ovr_err),
        .irq(irq), .vec(vec)
    );

    // monitor: compares one expected item per falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            tests++;
            if ({avail, par_err, ovr_err, irq, vec} !==
                {e.avail, e.par, e.ovr, e.irq, e.vec}) begin
                fails++;
                $display("FAIL %s: got avail=%b par=%b ovr=%b irq=%b vec=%b exp avail=%b par=%b ovr=%b irq=%b vec=%b",
                    e.tag, avail, par_err, ovr_err, irq, vec,
                    e.avail, e.par, e.ovr, e.irq, e.vec);
            end
        end
    end

    task automatic cfg(input logic [1:0] md, input logic sv, input logic ps);
        @(negedge clk);
        {char_top, char_par, char_ovr, rd_strobe, err_reset, rearm} = '0;
        int_mode = md; sav_en = sv; par_sc_en = ps;
    endtask

    task automatic step(input logic ct, pe, oe, rd, er, ra,
                        input logic ea, ep, eo, ei, input logic [1:0] ev,
                        input string tag);
        exp_t e;
        @(negedge clk);
        char_top = ct; char_par = pe; char_ovr = oe;
        rd_strobe = rd; err_reset = er; rearm = ra;
        @(posedge clk);
        #1;
        e.avail = ea; e.par = ep; e.ovr = eo; e.irq = ei; e.vec = ev; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        //    ct pe oe rd er ra   av pa ov irq vec
        step(0,0,0,0,0,0, 0,0,0,0,2'b00, "R1 reset state");
        step(1,0,0,0,0,0, 1,0,0,0,2'b00, "R2 R4 poll char");
        step(1,0,1,0,0,0, 1,0,1,0,2'b00, "R4 poll overrun no irq");
        step(0,0,0,1,0,0, 0,0,1,0,2'b00, "R2 R3 read keeps ovr");
        step(0,0,0,0,1,0, 0,0,0,0,2'b00, "R3 err reset");
        cfg(2'b10, 1, 0);
        step(1,0,0,0,0,0, 1,0,0,1,2'b01, "R5 every char irq");
        step(0,0,0,0,0,0, 1,0,0,1,2'b01, "R9 irq held");
        step(0,0,0,1,0,0, 0,0,0,0,2'b00, "R9 read drops irq");
        step(1,1,0,0,0,0, 1,1,0,1,2'b01, "R8 parity w/o enable normal");
        step(0,0,0,1,0,0, 0,1,0,0,2'b00, "R3 parity held");
        cfg(2'b10, 1, 1);
        step(1,0,0,0,0,0, 1,1,0,1,2'b10, "R8 held parity special");
        step(0,0,0,0,1,0, 1,0,0,0,2'b00, "R9 err reset drops special");
        step(0,0,0,1,0,0, 0,0,0,0,2'b00, "R2 read");
        cfg(2'b10, 0, 1);
        step(1,0,1,0,0,0, 1,0,1,1,2'b01, "R8 sav off code");
        step(1,0,0,1,0,0, 1,0,1,1,2'b01, "R2 read+char set wins");
        step(0,0,0,0,1,0, 1,0,0,0,2'b00, "R9 err reset special");
        step(0,0,0,1,0,0, 0,0,0,0,2'b00, "R2 read");
        step(1,0,0,0,1,0, 1,0,0,1,2'b01, "R3 setup");
        step(0,0,0,1,0,0, 0,0,0,0,2'b00, "R9 read");
        step(1,1,0,0,1,0, 1,1,0,1,2'b01, "R3 new error beats reset");
        step(0,0,0,1,1,0, 0,0,0,0,2'b00, "R3 clear");
        cfg(2'b01, 1, 1);
        step(1,0,0,0,0,0, 1,0,0,1,2'b01, "R6 first char irq");
        step(0,0,0,1,0,0, 0,0,0,0,2'b00, "R6 read");
        step(1,0,0,0,0,0, 1,0,0,0,2'b00, "R6 second char quiet");
        step(0,0,0,1,0,0, 0,0,0,0,2'b00, "R6 read");
        step(1,1,0,0,0,0, 1,1,0,0,2'b00, "R8 parity no irq first mode");
        step(0,0,0,1,0,0, 0,1,0,0,2'b00, "R3 parity held");
        step(1,0,1,0,0,0, 1,1,1,1,2'b10, "R8 overrun special first mode");
        step(0,0,0,0,1,0, 1,0,0,0,2'b00, "R9 R3 err reset");
        step(0,0,0,1,0,0, 0,0,0,0,2'b00, "R2 read");
        step(0,0,0,0,0,1, 0,0,0,0,2'b00, "R7 rearm silent");
        step(1,0,0,0,0,0, 1,0,0,1,2'b01, "R7 rearmed irq");
        step(0,0,0,1,0,0, 0,0,0,0,2'b00, "R7 read");
        cfg(2'b10, 1, 0);
        step(1,0,0,0,0,0, 1,0,0,1,2'b01, "R5 setup pending");
        cfg(2'b00, 1, 0);
        step(0,0,0,0,0,0, 1,0,0,0,2'b00, "R4 poll drops pending");
        step(0,0,0,1,0,0, 0,0,0,0,2'b00, "R2 read");
        cfg(2'b11, 1, 0);
        step(1,0,0,0,0,0, 1,0,0,1,2'b01, "R5 alt every code");
        step(0,0,0,1,0,0, 0,0,0,0,2'b00, "R9 read");
        cfg(2'b00, 1, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule